// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM

This block is a synthesizable, cycle-accurate model of a synchronous pipelined static RAM. A read and a write take the same two-cycle latency from address to data, so reads and writes can follow each other on every clock with no idle cycle on the data bus. The word is 72 bits wide and made of eight 9-bit byte lanes. Each lane has its own active-low write enable.

A controller starts a cycle by holding the load/advance input low with the chip select low. The write-enable level at that edge sets the cycle type. If load/advance is high while a burst is open, the model makes the next address of a four-beat burst by itself. The burst runs in linear or interleaved order, picked by a mode pin. The burst repeats the type of the cycle that opened it.

A high clock-enable input freezes the whole model. The sleep input freezes it too, after a two-cycle delay. An asynchronous output enable blanks the read port at any moment. The data input and data output are separate vectors, and the disabled output reads as all zeros.

Top module: `zt_sram`

## Requirements
- R1: An edge where `ce_n`=0, `cs_n`=0, `ld_n`=0 and `we_n`=1 opens a read. The word at `addr` appears on `dout`, with `dout_vld`=1, right after the second later enabled edge. It holds until the next enabled edge. After the first later enabled edge, `dout_vld` still shows the older command.
- R2: The same command with `we_n`=0 opens a write. `din` is sampled at the second enabled edge after the address edge.
- R3: Lane i is bits [9i+8:9i] of the word. A write changes lane i only if `bw_n[i]`=0 at that beat's address edge.
- R4: Reads and writes may be issued on consecutive edges in any mix. A read issued one edge after a write to the same address returns the newly written data.
- R5: An edge with `ce_n`=1 changes no state. Pipeline latencies count only edges with `ce_n`=0, so write data offered at a stalled edge is not taken.
- R6: With `lin_burst`=1, beat n of a burst uses address bits [1:0] = (start + n) mod 4. The upper bits stay those of the start address.
- R7: With `lin_burst`=0, beat n of a burst uses address bits [1:0] = start XOR n.
- R8: An edge with `ld_n`=0 and `cs_n`=1 is a deselect. It ends any burst and starts no cycle. After a deselect, or after reset, an edge with `ld_n`=1 starts no cycle.
- R9: `oe_n`=1 forces `dout` to zero and `dout_vld` to 0 at once, without a clock edge. Setting `oe_n`=0 brings the held read data back.
- R10: If `sleep` is 1 at an edge t, every edge from t+2 onward, while still asleep, is ignored. The array, the pipeline and the output register keep their contents.
- R11: If `sleep` is 0 at an edge u after sleeping, edges u and u+1 are still ignored. Edge u+2 and later edges work normally, and frozen operations resume in order.
- R12: With `rst`=1 at an edge, all pipeline valid state, the burst state and the sleep delay are cleared, and `dout_vld` is 0 afterwards.
- R13: A burst beat has the type of the cycle that opened the burst. Its byte lanes come from `bw_n` at that beat's own edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Clock enable, active low; high freezes the model |
| cs_n | input | 1 | Chip select for a load; high turns the load into a deselect |
| ld_n | input | 1 | Low loads a new address; high advances an open burst |
| we_n | input | 1 | Low at a load selects a write, high a read |
| bw_n | input | 8 | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address taken at a load |
| din | input | 72 | Write data, sampled two enabled edges after the address |
| lin_burst | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, acts two edges later |
| dout | output | 72 | Read data, zero while disabled |
| dout_vld | output | 1 | Marks cycles in which read data is driven |

## Verification
The checker assumes that `sleep` and `ce_n` are clean synchronous levels that change only between edges. It also assumes `lin_burst` does not change in the middle of a burst, and that `rst` is held from time zero until the first edges have passed. The bench changes every input one time unit after a rising edge and reads the outputs there. It holds the burst mode steady from the load to the last beat, and raises reset only at the start. Under these conditions, the two-edge delays of the sleep logic and the freeze under a stall can be stated directly against the inputs.

// File: rtl/zt_pkg.sv
package zt_pkg;

  localparam int BURST_BITS = 2;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low address bits of beat 'beat' for a burst that started at 'start'
  function automatic logic [BURST_BITS-1:0] burst_low(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] beat,
    input logic                  linear
  );
    logic [BURST_BITS-1:0] sum;
    sum = start + beat;
    return linear ? sum : (start ^ beat);
  endfunction

endpackage

// File: rtl/zt_sleep_ctl.sv
module zt_sleep_ctl #(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  output logic asleep
);

  logic [DELAY-1:0] sh_q;

  generate
    if (DELAY == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sleep_req;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[DELAY-2:0], sleep_req};
      end
    end
  endgenerate

  assign asleep = sh_q[DELAY-1];

endmodule

// File: rtl/zt_burst_gen.sv
module zt_burst_gen
  import zt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cs_n,
  input  logic              ld_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              linear,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  be_q
);

  localparam int BB = BURST_BITS;

  logic              open_q;
  logic              wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [BB-1:0]     beat_q;
  logic [BB-1:0]     next_low;

  assign next_low = burst_low(base_q[BB-1:0], beat_q, linear);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      op_q   <= OP_NONE;
      addr_q <= '0;
      be_q   <= '0;
    end else if (en) begin
      if (!ld_n) begin
        if (!cs_n) begin
          open_q <= 1'b1;
          wr_q   <= !we_n;
          base_q <= addr;
          beat_q <= BB'(1);
          op_q   <= we_n ? OP_READ : OP_WRITE;
          addr_q <= addr;
          be_q   <= ~bw_n;
        end else begin
          open_q <= 1'b0;
          op_q   <= OP_NONE;
        end
      end else if (open_q) begin
        beat_q <= beat_q + BB'(1);
        op_q   <= wr_q ? OP_WRITE : OP_READ;
        addr_q <= {base_q[ADDR_W-1:BB], next_low};
        be_q   <= ~bw_n;
      end else begin
        op_q   <= OP_NONE;
      end
    end
  end

endmodule

// File: rtl/zt_stage.sv
module zt_stage
  import zt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_o   <= OP_NONE;
      addr_o <= '0;
      be_o   <= '0;
    end else if (en) begin
      op_o   <= op_i;
      addr_o <= addr_i;
      be_o   <= be_i;
    end
  end

endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array
  import zt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      en,
  input  op_e                       op,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES-1:0]          be,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic do_wr;
  logic do_rd;

  assign do_wr = en && (op == OP_WRITE);
  assign do_rd = en && (op == OP_READ);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
        if (do_wr && be[l]) mem[addr] <= wdata[l*LANE_W +: LANE_W];
        if (do_rd)          rd_q      <= mem[addr];
      end

      assign rdata[l*LANE_W +: LANE_W] = rd_q;
    end
  endgenerate

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  parameter int LANE_W = 9,
  parameter int SLEEP_DELAY = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce_n,
  input  logic                    cs_n,
  input  logic                    ld_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    lin_burst,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_vld
);

  localparam int DW = LANES * LANE_W;

  logic              asleep;
  logic              act_en;
  op_e               op1;
  op_e               op2;
  logic [ADDR_W-1:0] addr1;
  logic [ADDR_W-1:0] addr2;
  logic [LANES-1:0]  be1;
  logic [LANES-1:0]  be2;
  logic [DW-1:0]     rd_data;
  logic              vld_q;

  zt_sleep_ctl #(.DELAY(SLEEP_DELAY)) sleep_i (
    .clk(clk), .rst(rst), .sleep_req(sleep), .asleep(asleep)
  );

  assign act_en = !ce_n && !asleep;

  zt_burst_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) front_i (
    .clk(clk), .rst(rst), .en(act_en), .cs_n(cs_n), .ld_n(ld_n),
    .we_n(we_n), .bw_n(bw_n), .addr(addr), .linear(lin_burst),
    .op_q(op1), .addr_q(addr1), .be_q(be1)
  );

  zt_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) stage_i (
    .clk(clk), .rst(rst), .en(act_en),
    .op_i(op1), .addr_i(addr1), .be_i(be1),
    .op_o(op2), .addr_o(addr2), .be_o(be2)
  );

  zt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk(clk), .en(act_en), .op(op2), .addr(addr2), .be(be2),
    .wdata(din), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst)         vld_q <= 1'b0;
    else if (act_en) vld_q <= (op2 == OP_READ);
  end

  assign dout     = oe_n ? '0 : rd_data;
  assign dout_vld = !oe_n && vld_q;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
  import zt_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic cs_n,
  input logic ld_n,
  input logic sleep,
  input logic act_en,
  input logic asleep,
  input op_e  op1,
  input op_e  op2,
  input logic vld_q
);

  // R1: an accepted load opens a cycle in the first stage
  p_load_opens_r1: assert property (@(posedge clk) disable iff (rst)
    (act_en && !ld_n && !cs_n) |=> (op1 != OP_NONE));

  // R1: a read leaving the second stage marks the output valid
  p_read_valid_r1: assert property (@(posedge clk) disable iff (rst)
    (act_en && op2 == OP_READ) |=> vld_q);

  // R8: a deselect leaves the first stage empty
  p_deselect_r8: assert property (@(posedge clk) disable iff (rst)
    (act_en && !ld_n && cs_n) |=> (op1 == OP_NONE));

  // R5: a stalled edge changes no pipeline state
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> ($stable(op1) && $stable(op2) && $stable(vld_q)));

  // R10: sleep takes hold two edges after it is seen
  p_sleep_enter_r10: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ##1 asleep);

  // R10: nothing moves while asleep
  p_sleep_hold_r10: assert property (@(posedge clk) disable iff (rst)
    asleep |=> ($stable(op1) && $stable(op2) && $stable(vld_q)));

  // R11: wake two edges after sleep is seen low
  p_sleep_exit_r11: assert property (@(posedge clk) disable iff (rst)
    !sleep |=> ##1 !asleep);

endmodule

bind zt_sram zt_sram_chk chk_i (
  .clk(clk), .rst(rst), .ce_n(ce_n), .cs_n(cs_n), .ld_n(ld_n),
  .sleep(sleep), .act_en(act_en), .asleep(asleep),
  .op1(op1), .op2(op2), .vld_q(vld_q)
);

// File: tb/zt_sram_tb_top.sv
`timescale 1ns/1ps
module zt_sram_tb_top;

  localparam int AW = 6;
  localparam int NL = 8;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          ld_n = 1'b0;
  logic          we_n = 1'b1;
  logic [NL-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          lin_burst = 1'b1;
  logic          oe_n = 1'b0;
  logic          sleep = 1'b0;
  logic [DW-1:0] dout;
  logic          dout_vld;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [DW-1:0] shadow [1 << AW];

  always #2 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cs_n(cs_n), .ld_n(ld_n),
    .we_n(we_n), .bw_n(bw_n), .addr(addr), .din(din),
    .lin_burst(lin_burst), .oe_n(oe_n), .sleep(sleep),
    .dout(dout), .dout_vld(dout_vld)
  );

  function automatic logic [DW-1:0] mk(input int a, input int s);
    logic [DW-1:0] r;
    for (int l = 0; l < NL; l++) r[l*LW +: LW] = LW'(a * 37 + s * 11 + l * 5 + 1);
    return r;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one edge: inputs applied now, outputs readable on return
  task automatic cyc(input logic c, input logic s, input logic l, input logic w,
                     input logic [NL-1:0] b, input int a, input logic [DW-1:0] d);
    ce_n = c; cs_n = s; ld_n = l; we_n = w; bw_n = b; addr = AW'(a); din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic desel(input logic [DW-1:0] d);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, '1, 0, d);
  endtask

  task automatic adv(input logic [NL-1:0] b, input logic [DW-1:0] d);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, b, 0, d);
  endtask

  task automatic write_word(input int a, input logic [DW-1:0] d);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, a, '0);
    desel('0);
    desel(d);
    shadow[a] = d;
  endtask

  task automatic read_chk(input int a, input string req);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, '1, a, '0);
    desel('0);
    desel('0);
    chk({req, " data"}, dout, shadow[a]);
    chk({req, " valid"}, DW'(dout_vld), DW'(1));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) desel('0);
    rst = 1'b0;
    desel('0);
    chk("R12 valid low after reset", DW'(dout_vld), DW'(0));
  endtask

  task automatic t_basic;
    write_word(5, mk(5, 1));
    cyc(1'b0, 1'b0, 1'b0, 1'b1, '1, 5, '0);
    desel('0);
    chk("R1 not yet valid after one edge", DW'(dout_vld), DW'(0));
    desel('0);
    chk("R1 R2 read back", dout, shadow[5]);
    chk("R1 valid", DW'(dout_vld), DW'(1));
    write_word(6, mk(6, 1));
    read_chk(6, "R2 second word");
  endtask

  task automatic t_lanes;
    logic [DW-1:0] y;
    logic [DW-1:0] m;
    write_word(10, mk(10, 2));
    y = mk(10, 9);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'b1010_1010, 10, '0);
    desel('0);
    desel(y);
    m = shadow[10];
    for (int l = 0; l < NL; l += 2) m[l*LW +: LW] = y[l*LW +: LW];
    shadow[10] = m;
    read_chk(10, "R3 even lanes merged");
  endtask

  task automatic t_b2b;
    logic [DW-1:0] d7;
    logic [DW-1:0] d8;
    d7 = mk(7, 3);
    d8 = mk(8, 3);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, 7, '0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, '1, 7, '0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, 8, d7);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, '1, 8, '0);
    chk("R4 read after write same address", dout, d7);
    chk("R4 valid", DW'(dout_vld), DW'(1));
    desel(d8);
    chk("R4 write slot clears valid", DW'(dout_vld), DW'(0));
    desel('0);
    chk("R4 second read after write", dout, d8);
    shadow[7] = d7;
    shadow[8] = d8;
  endtask

  task automatic t_stall;
    cyc(1'b0, 1'b0, 1'b0, 1'b1, '1, 5, '0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, '0, 9, mk(9, 7));
    chk("R5 stalled edge no valid", DW'(dout_vld), DW'(0));
    cyc(1'b1, 1'b0, 1'b0, 1'b0, '0, 9, mk(9, 7));
    desel('0);
    chk("R5 latency counts active edges", DW'(dout_vld), DW'(0));
    desel('0);
    chk("R5 read after stall", dout, shadow[5]);
    write_word(9, mk(9, 4));
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, 9, '0);
    desel('0);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, '1, 0, mk(9, 8));
    desel(mk(9, 5));
    shadow[9] = mk(9, 5);
    read_chk(9, "R5 write data from active edge");
  endtask

  function automatic int bexp(input int start, input int n, input bit lin);
    int lo;
    lo = lin ? ((start + n) & 3) : ((start ^ n) & 3);
    return (start & ~3) | lo;
  endfunction

  task automatic burst_read(input int start, input bit lin, input string req);
    lin_burst = lin;
    cyc(1'b0, 1'b0, 1'b0, 1'b1, '1, start, '0);
    adv('1, '0);
    for (int n = 0; n < 4; n++) begin
      if (n < 2) adv('1, '0);
      else       desel('0);
      chk(req, dout, shadow[bexp(start, n, lin)]);
    end
  endtask

  task automatic t_bursts;
    for (int a = 16; a < 24; a++) write_word(a, mk(a, 6));
    burst_read(18, 1'b1, "R6 linear beat");
    burst_read(17, 1'b0, "R7 interleaved beat");
    burst_read(23, 1'b0, "R7 interleaved from 3");
  endtask

  task automatic t_burst_write;
    lin_burst = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, 20, '0);
    adv('1, '0);
    adv('0, mk(20, 9));
    adv('0, mk(21, 9));
    desel(mk(22, 9));
    desel(mk(23, 9));
    shadow[20] = mk(20, 9);
    shadow[22] = mk(22, 9);
    shadow[23] = mk(23, 9);
    read_chk(20, "R13 burst write beat0");
    read_chk(21, "R13 masked beat unchanged");
    read_chk(22, "R13 burst write beat2");
    read_chk(23, "R13 burst write beat3");
  endtask

  task automatic t_no_burst;
    repeat (3) desel('0);
    for (int i = 0; i < 4; i++) begin
      adv('1, '0);
      chk("R8 advance without burst", DW'(dout_vld), DW'(0));
    end
  endtask

  task automatic t_oe;
    read_chk(8, "R9 setup");
    oe_n = 1'b1;
    #1;
    chk("R9 output forced off", dout, '0);
    chk("R9 valid forced off", DW'(dout_vld), DW'(0));
    oe_n = 1'b0;
    #1;
    chk("R9 output restored", dout, shadow[8]);
  endtask

  task automatic t_sleep;
    desel('0);
    desel('0);
    sleep = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b1, '1, 5, '0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, '1, 6, '0);
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, 5, mk(5, 13));
      chk("R10 commands ignored asleep", DW'(dout_vld), DW'(0));
    end
    sleep = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, 5, mk(5, 14));
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, 5, mk(5, 15));
    chk("R11 still asleep during wake delay", DW'(dout_vld), DW'(0));
    desel('0);
    chk("R11 frozen read resumes", dout, shadow[5]);
    chk("R11 valid after wake", DW'(dout_vld), DW'(1));
    desel('0);
    chk("R10 second frozen read", dout, shadow[6]);
    read_chk(5, "R10 array kept");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_lanes();
    t_b2b();
    t_stall();
    t_bursts();
    t_burst_write();
    t_no_burst();
    t_oe();
    t_sleep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule